// File: doc/BRIEF.md
# Fetch Redirect and Instruction Kill Control

This block steers the fetch stage of a five-stage in-order pipeline. It looks at the opcode sitting in decode and the opcode sitting in execute, at the zero flag of the branch operand in execute, and at the hazard stall. From these it picks where the next program counter comes from, and whether the decode and execute instruction registers capture a bubble or their normal input. It is purely combinational. The PC register, the instruction registers, the target adders and the instruction memory belong to the surrounding pipeline.

Fetch always guesses the sequential address. Unconditional jumps are known in decode and cost one bubble. Conditional branches are resolved in execute and cost two bubbles when taken. There are no delay slots. When two redirects fall in the same cycle, the older instruction wins: a taken branch in execute overrides a jump in decode. A jump held in decode by a stall does not act until the stall clears, so the jump itself is never discarded.

Top module: `fetch_redirect_ctrl`

## Requirements
- R1: Opcode 0x04 (branch if zero) with `exe_operand_zero`=1, or opcode 0x05 (branch if nonzero) with `exe_operand_zero`=0, in execute drives `pc_sel`=1 (branch target), whatever decode holds and whatever `stall` is.
- R2: With no taken branch and `stall`=0, opcode 0x02 or 0x03 (absolute jump, with or without link) in decode drives `pc_sel`=2.
- R3: With no taken branch and `stall`=0, opcode 0x08 or 0x09 (register jump, with or without link) in decode drives `pc_sel`=3.
- R4: In all other cases `pc_sel`=0 (sequential address). This includes untaken branches and every other opcode value.
- R5: A taken branch sets both `dec_ir_kill` and `exe_ir_kill`, which removes the two younger instructions.
- R6: A decode jump that acts (no taken branch, `stall`=0) sets `dec_ir_kill`=1 and `exe_ir_kill`=0, so only the one instruction fetched behind it is removed.
- R7: `stall`=1 with no taken branch gives `exe_ir_kill`=1, `pc_load_en`=0, `dec_ir_load_en`=0, `dec_ir_kill`=0 and `pc_sel`=0, even if decode holds a jump.
- R8: With no stall and no redirect, `pc_load_en`=1, `dec_ir_load_en`=1 and neither kill is set.
- R9: A taken branch overrides `stall`: `pc_load_en`=1 and `dec_ir_load_en`=1.
- R10: A pipeline built around the block retires the same instruction addresses, in the same order, as a sequential interpreter of the same program, under random stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_opcode | input | OPW (6) | Opcode of the instruction in decode (0x00 when decode is empty) |
| exe_opcode | input | OPW (6) | Opcode of the instruction in execute (0x00 when execute is empty) |
| exe_operand_zero | input | 1 | Branch operand in execute equals zero |
| stall | input | 1 | Hazard stall of the decode instruction |
| pc_sel | output | 2 | 0 sequential, 1 branch target, 2 absolute jump target, 3 register target |
| dec_ir_kill | output | 1 | Decode instruction register takes a bubble |
| exe_ir_kill | output | 1 | Execute instruction register takes a bubble instead of the decode instruction |
| pc_load_en | output | 1 | PC register captures the selected next address |
| dec_ir_load_en | output | 1 | Decode instruction register updates (bubble or fetched word) |

## Verification
The two functions that can collide are a taken branch in execute and a jump in decode. A stall may also fall in that same cycle. The random phase weights opcodes towards branches and jumps in both stages and raises `stall` often, so these overlaps come up many times. A few directed cases force the exact combinations. Each cycle is judged against a bench model in which the branch must win and must ignore the stall. The pipeline runs then show that neither a deferred jump nor an overridden jump is lost or repeated in the retired stream.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [1:0] {
    PCS_SEQ    = 2'd0,
    PCS_BRANCH = 2'd1,
    PCS_ABS    = 2'd2,
    PCS_REG    = 2'd3
  } pc_src_e;

  typedef struct packed {
    logic br_eqz;
    logic br_nez;
    logic jmp_abs;
    logic jmp_reg;
  } op_class_t;

  localparam int NUM_STAGES = 2;
  localparam int STG_DEC = 0;
  localparam int STG_EXE = 1;
endpackage

// File: rtl/op_classify.sv
module op_classify
  import frc_pkg::*;
#(
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OP_BEQZ = 6'h04,
  parameter logic [OPW-1:0] OP_BNEZ = 6'h05,
  parameter logic [OPW-1:0] OP_J    = 6'h02,
  parameter logic [OPW-1:0] OP_JAL  = 6'h03,
  parameter logic [OPW-1:0] OP_JR   = 6'h08,
  parameter logic [OPW-1:0] OP_JALR = 6'h09
) (
  input  logic [OPW-1:0] opcode,
  output op_class_t      cls
);
  always_comb begin
    cls         = '0;
    cls.br_eqz  = (opcode == OP_BEQZ);
    cls.br_nez  = (opcode == OP_BNEZ);
    cls.jmp_abs = (opcode == OP_J)  || (opcode == OP_JAL);
    cls.jmp_reg = (opcode == OP_JR) || (opcode == OP_JALR);
  end

  // R4: an opcode belongs to at most one control class
  always_comb begin
    assert_one_class_R4: assert ($onehot0(cls));
  end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import frc_pkg::*;
(
  input  op_class_t exe_cls,
  input  logic      operand_zero,
  output logic      taken
);
  logic eqz_hit, nez_hit;

  always_comb begin
    eqz_hit = exe_cls.br_eqz &  operand_zero;
    nez_hit = exe_cls.br_nez & ~operand_zero;
    taken   = eqz_hit | nez_hit;
  end

  // R1: a taken outcome needs a conditional branch in execute
  always_comb begin
    assert_taken_needs_branch_R1: assert (!taken || exe_cls.br_eqz || exe_cls.br_nez);
  end
endmodule

// File: rtl/redirect_arbiter.sv
module redirect_arbiter
  import frc_pkg::*;
(
  input  logic      br_taken,
  input  op_class_t dec_cls,
  input  logic      stall,
  output pc_src_e   pc_sel,
  output logic      dec_ir_kill,
  output logic      exe_ir_kill,
  output logic      pc_load_en,
  output logic      dec_ir_load_en
);
  logic dec_jump, jump_fires, advance;

  always_comb begin
    dec_jump   = dec_cls.jmp_abs | dec_cls.jmp_reg;
    jump_fires = dec_jump & ~stall & ~br_taken;
    advance    = br_taken | ~stall;

    // older instruction first: execute branch, then decode jump
    if (br_taken)                 pc_sel = PCS_BRANCH;
    else if (jump_fires && dec_cls.jmp_abs) pc_sel = PCS_ABS;
    else if (jump_fires)          pc_sel = PCS_REG;
    else                          pc_sel = PCS_SEQ;

    dec_ir_kill    = br_taken | jump_fires;
    exe_ir_kill    = br_taken | stall;
    pc_load_en     = advance;
    dec_ir_load_en = advance;
  end

  // R7: a held PC never carries a redirect
  always_comb begin
    assert_hold_no_redirect_R7: assert (pc_load_en || (pc_sel == PCS_SEQ && !dec_ir_kill));
  end
endmodule

// File: rtl/fetch_redirect_ctrl.sv
module fetch_redirect_ctrl
  import frc_pkg::*;
#(
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OP_BEQZ = 6'h04,
  parameter logic [OPW-1:0] OP_BNEZ = 6'h05,
  parameter logic [OPW-1:0] OP_J    = 6'h02,
  parameter logic [OPW-1:0] OP_JAL  = 6'h03,
  parameter logic [OPW-1:0] OP_JR   = 6'h08,
  parameter logic [OPW-1:0] OP_JALR = 6'h09
) (
  input  logic [OPW-1:0] dec_opcode,
  input  logic [OPW-1:0] exe_opcode,
  input  logic           exe_operand_zero,
  input  logic           stall,
  output logic [1:0]     pc_sel,
  output logic           dec_ir_kill,
  output logic           exe_ir_kill,
  output logic           pc_load_en,
  output logic           dec_ir_load_en
);
  logic [OPW-1:0] stage_op  [NUM_STAGES];
  op_class_t      stage_cls [NUM_STAGES];
  logic           br_taken;
  pc_src_e        pc_src;

  assign stage_op[STG_DEC] = dec_opcode;
  assign stage_op[STG_EXE] = exe_opcode;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_cls
    op_classify #(
      .OPW(OPW), .OP_BEQZ(OP_BEQZ), .OP_BNEZ(OP_BNEZ),
      .OP_J(OP_J), .OP_JAL(OP_JAL), .OP_JR(OP_JR), .OP_JALR(OP_JALR)
    ) i_cls (
      .opcode (stage_op[s]),
      .cls    (stage_cls[s])
    );
  end

  branch_resolve i_resolve (
    .exe_cls      (stage_cls[STG_EXE]),
    .operand_zero (exe_operand_zero),
    .taken        (br_taken)
  );

  redirect_arbiter i_arb (
    .br_taken       (br_taken),
    .dec_cls        (stage_cls[STG_DEC]),
    .stall          (stall),
    .pc_sel         (pc_src),
    .dec_ir_kill    (dec_ir_kill),
    .exe_ir_kill    (exe_ir_kill),
    .pc_load_en     (pc_load_en),
    .dec_ir_load_en (dec_ir_load_en)
  );

  assign pc_sel = pc_src;

  always_comb begin
    // R5: a branch redirect removes both younger instructions
    assert_branch_kills_two_R5: assert (pc_sel != PCS_BRANCH || (dec_ir_kill && exe_ir_kill));
    // R6: a jump redirect removes only the decode slot
    assert_jump_kills_one_R6: assert (!(pc_sel == PCS_ABS || pc_sel == PCS_REG) || (dec_ir_kill && !exe_ir_kill));
    // R7: execute keeps its input only when nothing stalls or branches
    assert_exe_pass_R7: assert (exe_ir_kill || (!stall && pc_sel != PCS_BRANCH));
    // R9: a taken branch always lets the PC advance
    assert_branch_advances_R9: assert (pc_sel != PCS_BRANCH || (pc_load_en && dec_ir_load_en));
  end
endmodule

// File: tb/test_fetch_redirect_ctrl.sv
module test_fetch_redirect_ctrl;
  localparam logic [5:0] C_NOP = 6'h00, C_BEQZ = 6'h04, C_BNEZ = 6'h05,
                         C_J = 6'h02, C_JAL = 6'h03, C_JR = 6'h08, C_JALR = 6'h09;
  localparam int PROG = 16;
  localparam int NRET = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [5:0] dop, eop;
  logic       ez, st;
  logic [1:0] pc_sel;
  logic       dk, ek, pl, dl;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  fetch_redirect_ctrl i_fetch_redirect_ctrl (
    .dec_opcode(dop), .exe_opcode(eop), .exe_operand_zero(ez), .stall(st),
    .pc_sel(pc_sel), .dec_ir_kill(dk), .exe_ir_kill(ek),
    .pc_load_en(pl), .dec_ir_load_en(dl)
  );

  function automatic logic [5:0] model(logic [5:0] d, logic [5:0] e, logic z, logic s);
    logic tk, ja, jr, fire;
    logic [1:0] ps;
    tk   = (e == C_BEQZ && z) || (e == C_BNEZ && !z);
    ja   = (d == C_J) || (d == C_JAL);
    jr   = (d == C_JR) || (d == C_JALR);
    fire = (ja || jr) && !s && !tk;
    ps   = tk ? 2'd1 : (fire && ja) ? 2'd2 : fire ? 2'd3 : 2'd0;
    return {ps, tk || fire, tk || s, tk || !s, tk || !s};
  endfunction

  function automatic logic [5:0] pick_op();
    case ($urandom % 9)
      0: return C_BEQZ; 1: return C_BNEZ; 2: return C_J; 3: return C_JAL;
      4: return C_JR;   5: return C_JALR; 6: return C_NOP;
      default: return 6'($urandom);
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic apply(logic [5:0] d, logic [5:0] e, logic z, logic s, string req);
    dop = d; eop = e; ez = z; st = s;
    #2;
    check(req, {26'd0, pc_sel, dk, ek, pl, dl}, {26'd0, model(d, e, z, s)});
  endtask

  int unsigned p_op [PROG];
  int unsigned p_tg [PROG];
  bit          p_z  [PROG];

  function automatic bit is_taken(int unsigned a);
    return (p_op[a] == C_BEQZ && p_z[a]) || (p_op[a] == C_BNEZ && !p_z[a]);
  endfunction

  task automatic run_program(int unsigned stall_pct);
    int unsigned exp_tr [NRET];
    int unsigned got_tr [NRET];
    int unsigned pc = 0, dpc = 0, epc = 0, n = 0, a = 0;
    bit dv = 0, ev = 0, mismatch = 0;
    for (int i = 0; i < PROG; i++) begin
      p_op[i] = 32'(pick_op());
      p_tg[i] = $urandom % PROG;
      p_z[i]  = 1'($urandom);
    end
    for (int k = 0; k < NRET; k++) begin
      logic [5:0] o;
      exp_tr[k] = a;
      o = p_op[a][5:0];
      if (is_taken(a) || o == C_J || o == C_JAL || o == C_JR || o == C_JALR) a = p_tg[a];
      else a = (a + 1) % PROG;
    end
    for (int cyc = 0; cyc < 600 && n < NRET; cyc++) begin
      @(negedge clk);
      dop = dv ? p_op[dpc][5:0] : C_NOP;
      eop = ev ? p_op[epc][5:0] : C_NOP;
      ez  = ev ? p_z[epc] : 1'b0;
      st  = dv && (($urandom % 100) < stall_pct);
      #2;
      if (ev) begin got_tr[n] = epc; n++; end
      begin
        int unsigned npc = pc;
        if (pl) case (pc_sel)
          2'd0: npc = (pc + 1) % PROG;
          2'd1: npc = p_tg[epc];
          default: npc = p_tg[dpc];
        endcase
        if (ek) ev = 0; else begin ev = dv; epc = dpc; end
        if (dk) dv = 0; else if (dl) begin dv = 1; dpc = pc; end
        pc = npc;
      end
    end
    check("R10 retired count", n, NRET);
    for (int k = 0; k < NRET && k < int'(n); k++)
      if (got_tr[k] != exp_tr[k] && !mismatch) begin
        mismatch = 1;
        check("R10 retired order", got_tr[k], exp_tr[k]);
      end
    if (!mismatch) check("R10 retired order", 0, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    dop = C_NOP; eop = C_NOP; ez = 0; st = 0;
    #3;
    // idle state with empty stages
    check("R8 idle", {28'd0, pc_sel, dk, ek}, 32'd0);
    check("R8 idle loads", {30'd0, pl, dl}, 32'd3);
    apply(C_NOP, C_BEQZ, 1'b1, 1'b0, "R1 beqz taken");
    apply(C_NOP, C_BNEZ, 1'b0, 1'b0, "R1 bnez taken");
    apply(C_NOP, C_BEQZ, 1'b0, 1'b0, "R4 beqz untaken");
    apply(C_NOP, C_BNEZ, 1'b1, 1'b0, "R4 bnez untaken");
    apply(C_J,   C_NOP, 1'b0, 1'b0, "R2 J");
    apply(C_JAL, C_NOP, 1'b1, 1'b0, "R2 JAL");
    apply(C_JR,  C_NOP, 1'b0, 1'b0, "R3 JR");
    apply(C_JALR,C_NOP, 1'b0, 1'b0, "R3 JALR");
    apply(C_JR,  C_BEQZ, 1'b1, 1'b0, "R5 branch beats jump");
    apply(C_J,   C_BNEZ, 1'b0, 1'b1, "R9 branch beats stall and jump");
    apply(C_JAL, C_NOP, 1'b0, 1'b1, "R7 stalled jump deferred");
    apply(C_J,   C_BEQZ, 1'b0, 1'b1, "R6 untaken branch, stalled jump");
    apply(C_JALR,C_BNEZ, 1'b1, 1'b0, "R6 untaken branch, jump fires");
    apply(6'h3f, 6'h3f, 1'b1, 1'b0, "R4 unused code");
    apply(C_NOP, C_NOP, 1'b0, 1'b1, "R7 plain stall");
    for (int i = 0; i < 3000; i++)
      apply(pick_op(), pick_op(), 1'($urandom), 1'(($urandom % 3) == 0), "R1-mix random");
    run_program(0);
    run_program(25);
    run_program(50);
    run_program(25);
    run_program(70);
    run_program(10);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule